// File: doc/BRIEF.md
# Checkerboard Memory Test Engine

This block runs a destructive static fault test on a single-port synchronous RAM that covers a power-of-two address space. After a start pulse it fills every cell with an alternating checkerboard word. The word is chosen by the lowest address bit. The block then inspects the memory in pairs. A variable address walks from the bottom of the space to the top and back down again. At each step the cell at the variable address is read first, then the cell whose address is the full bitwise complement of it. Each read is compared with the word the pattern says it should hold.

When the first phase is clean, the whole fill-and-inspect sequence runs once more with the two checkerboard words swapped, so that every bit of every cell has been tested at both levels. The first mismatch stops the run. It raises a fail flag and holds the address that was read and the word that was expected there. A clean run ends with a done flag. The test targets stuck-at faults and does not put back what the application had stored in the RAM.

Top module: `cbmt_engine`

## Requirements
- R1: After reset, done, fail and mem_en are low, and no RAM access happens until start is pulsed.
- R2: Each phase begins with N = 2^AW writes at ascending addresses 0 to N-1 on consecutive cycles. In phase 0 the data is 0x55… when address bit 0 is 0 and 0xAA… when it is 1, so consecutive writes alternate.
- R3: After a fill, reads come in pairs. The second read of a pair is at the address whose AW bits are all the complement of the first read's address.
- R4: In one inspection the variable address takes the values 0, 1, … N-1 and then N-1, N-2, … 0, which gives 4N reads per phase. Each read is compared with the phase's pattern word for the address read.
- R5: After a clean phase 0, a second fill and inspection run with the two words swapped: 0xAA… at even and 0x55… at odd addresses. A full run is 10N accesses.
- R6: On the first read whose data differs from its expected word, fail goes high, fail_addr holds that read's address and fail_expect holds the expected word. At most one further read follows on the RAM port, and no access follows once fail is high.
- R7: A run with no mismatch ends with done high and fail low. Done and fail are never high together, and each stays high until the next accepted start.
- R8: A start pulse during a run is ignored and the run continues unchanged. A start after a finished or failed run clears done and fail and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a test |
| done | output | 1 | Test finished without mismatch |
| fail | output | 1 | Test stopped on a mismatch |
| fail_addr | output | AW | Address of the first mismatching read |
| fail_expect | output | DW | Word expected at fail_addr |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable (with mem_en) |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data, one cycle after a read |

## Verification
On every cycle the assertions check several properties of the RAM port. Fill writes must climb one address at a time with alternating data. The second read of each pair must land on the complement of the first. The port must stay quiet while done or fail is shown, and the two flags must hold their values and never appear together. The exact order of all ten passes over the space, the swap of the pattern in the second phase, and which address and word get latched can only be shown by the bench's scenarios. These scenarios inject stuck bits that surface in different places: as a variable read, as a partner read, or only after the pattern is inverted.

// File: rtl/cbmt_pkg.sv
package cbmt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_UP, ST_DOWN} cb_stage_t;
endpackage

// File: rtl/cbmt_seq.sv
module cbmt_seq import cbmt_pkg::*; #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          abort,
  output logic          busy,
  output logic          bus_en,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic          bus_last
);
  localparam logic [AW-1:0] A_MAX = '1;

  cb_stage_t     stage;
  logic          phase;
  logic          sub;
  logic [AW-1:0] cnt;
  logic [AW-1:0] tgt;

  // checkerboard word: bit i is set when i is even, flipped by addr[0] and phase
  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input logic ph);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) begin
      r[i] = (i[0] == 1'b0) ^ a[0] ^ ph;
    end
    return r;
  endfunction

  assign tgt  = sub ? ~cnt : cnt;
  assign busy = (stage != ST_IDLE) || bus_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage    <= ST_IDLE;
      phase    <= 1'b0;
      sub      <= 1'b0;
      cnt      <= '0;
      bus_en   <= 1'b0;
      bus_we   <= 1'b0;
      bus_addr <= '0;
      bus_data <= '0;
      bus_last <= 1'b0;
    end else begin
      bus_en   <= 1'b0;
      bus_we   <= 1'b0;
      bus_last <= 1'b0;
      if (abort) begin
        stage <= ST_IDLE;
      end else begin
        case (stage)
          ST_IDLE: begin
            if (go) begin
              stage <= ST_FILL;
              phase <= 1'b0;
              cnt   <= '0;
              sub   <= 1'b0;
            end
          end
          ST_FILL: begin
            bus_en   <= 1'b1;
            bus_we   <= 1'b1;
            bus_addr <= cnt;
            bus_data <= pat(cnt, phase);
            if (cnt == A_MAX) begin
              cnt   <= '0;
              sub   <= 1'b0;
              stage <= ST_UP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_UP, ST_DOWN: begin
            bus_en   <= 1'b1;
            bus_addr <= tgt;
            bus_data <= pat(tgt, phase);
            sub      <= ~sub;
            if (sub) begin
              if (stage == ST_UP) begin
                if (cnt == A_MAX) stage <= ST_DOWN;
                else              cnt   <= cnt + 1'b1;
              end else if (cnt == '0) begin
                if (!phase) begin
                  phase <= 1'b1;
                  stage <= ST_FILL;
                end else begin
                  stage    <= ST_IDLE;
                  bus_last <= 1'b1;
                end
              end else begin
                cnt <= cnt - 1'b1;
              end
            end
          end
          default: stage <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cbmt_cmp.sv
module cbmt_cmp #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_last,
  input  logic [DW-1:0] rdata,
  output logic          pend,
  output logic          mismatch,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_expect
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;
  logic          last_q;

  assign mismatch = pend && !fail && (rdata != exp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend        <= 1'b0;
      addr_q      <= '0;
      exp_q       <= '0;
      last_q      <= 1'b0;
      done        <= 1'b0;
      fail        <= 1'b0;
      fail_addr   <= '0;
      fail_expect <= '0;
    end else begin
      pend   <= bus_rd;
      addr_q <= bus_addr;
      exp_q  <= bus_data;
      last_q <= bus_last;
      if (clr) begin
        done <= 1'b0;
        fail <= 1'b0;
      end else if (mismatch) begin
        fail        <= 1'b1;
        fail_addr   <= addr_q;
        fail_expect <= exp_q;
      end else if (pend && last_q && !fail) begin
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cbmt_engine.sv
module cbmt_engine #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_expect,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic seq_busy, cmp_pend, mismatch, accept, bus_last;

  assign accept = start && !seq_busy && !cmp_pend;

  cbmt_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .go       (accept),
    .abort    (mismatch),
    .busy     (seq_busy),
    .bus_en   (mem_en),
    .bus_we   (mem_we),
    .bus_addr (mem_addr),
    .bus_data (mem_wdata),
    .bus_last (bus_last)
  );

  cbmt_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .clk         (clk),
    .rst         (rst),
    .clr         (accept),
    .bus_rd      (mem_en && !mem_we),
    .bus_addr    (mem_addr),
    .bus_data    (mem_wdata),
    .bus_last    (bus_last),
    .rdata       (mem_rdata),
    .pend        (cmp_pend),
    .mismatch    (mismatch),
    .done        (done),
    .fail        (fail),
    .fail_addr   (fail_addr),
    .fail_expect (fail_expect)
  );
endmodule

// File: rtl/cbmt_engine_chk.sv
module cbmt_engine_chk #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic          fail,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata
);
  logic [DW-1:0] w_even, w_odd;
  logic          rd_par;
  logic [AW-1:0] prev_rd;

  always_comb begin
    for (int i = 0; i < DW; i++) begin
      w_even[i] = (i[0] == 1'b0);
      w_odd[i]  = (i[0] == 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || (mem_en && mem_we)) begin
      rd_par  <= 1'b0;
      prev_rd <= '0;
    end else if (mem_en) begin
      rd_par  <= ~rd_par;
      prev_rd <= mem_addr;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_en && !done && !fail));

  // R2
  fill_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we && $past(mem_en && mem_we)) |->
      (mem_addr == AW'($past(mem_addr) + 1'b1)) && (mem_wdata == ~$past(mem_wdata)));

  // R2
  fill_word_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |-> (mem_wdata == w_even || mem_wdata == w_odd));

  // R3
  pair_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we && rd_par) |-> (mem_addr == ~prev_rd));

  // R6
  quiet_after_end_chk: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> !mem_en);

  // R6
  fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> fail);

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));
endmodule

bind cbmt_engine cbmt_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .fail(fail),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/sim_cbmt_engine.sv
module sim_cbmt_engine;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } op_t;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic done, fail, mem_en, mem_we;
  logic [AW-1:0] fail_addr, mem_addr;
  logic [DW-1:0] fail_expect, mem_wdata, mem_rdata;

  logic [DW-1:0] ram [N];
  logic          flt_en = 1'b0;
  logic [AW-1:0] flt_addr = '0;
  logic [DW-1:0] flt_mask = '0, flt_val = '0;

  op_t q[$];
  int  checks = 0, errors = 0, ops_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbmt_engine #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .start(start), .done(done), .fail(fail),
    .fail_addr(fail_addr), .fail_expect(fail_expect),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // RAM model with one optional stuck-bit cell
  always @(posedge clk) begin
    if (mem_en && mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_en && !mem_we) begin
      if (flt_en && mem_addr == flt_addr)
        mem_rdata <= (ram[mem_addr] & ~flt_mask) | (flt_val & flt_mask);
      else
        mem_rdata <= ram[mem_addr];
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] patw(input logic [AW-1:0] a, input int ph);
    return ((a[0] ^ ph[0]) == 1'b0) ? 8'h55 : 8'hAA;
  endfunction

  // driver: expected access sequence from R2..R5
  task automatic push_run();
    q.delete();
    for (int ph = 0; ph < 2; ph++) begin
      for (int a = 0; a < N; a++) q.push_back({1'b1, AW'(a), patw(AW'(a), ph)});
      for (int a = 0; a < N; a++) begin
        q.push_back({1'b0, AW'(a), 8'h00});
        q.push_back({1'b0, ~AW'(a), 8'h00});
      end
      for (int a = N - 1; a >= 0; a--) begin
        q.push_back({1'b0, AW'(a), 8'h00});
        q.push_back({1'b0, ~AW'(a), 8'h00});
      end
    end
  endtask

  // monitor: pops and compares every RAM access
  always @(negedge clk) begin
    if (!rst && mem_en) begin
      ops_seen++;
      if (q.size() == 0) begin
        check(1'b0, "R4 unexpected access", {23'd0, mem_we, mem_addr, 4'd0}, 0);
      end else begin
        op_t e;
        e = q.pop_front();
        check(mem_we == e.we && mem_addr == e.a && (!e.we || mem_wdata == e.d),
              "R2/R3/R5 access order", {mem_we, mem_addr, mem_wdata},
              {e.we, e.a, e.d});
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || fail) && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check(n < 4000, "R7 run ended", n, 0);
  endtask

  task automatic fault_run(input logic [AW-1:0] fa, input logic [DW-1:0] m,
                           input logic [DW-1:0] v, input logic [DW-1:0] ex, input string tag);
    flt_en = 1'b1; flt_addr = fa; flt_mask = m; flt_val = v;
    push_run();
    pulse_start();
    wait_end();
    check(fail == 1'b1 && done == 1'b0, {tag, " fail flag"}, {fail, done}, 2'b10);
    check(fail_addr == fa, {tag, " fail_addr"}, fail_addr, fa);
    check(fail_expect == ex, {tag, " fail_expect"}, fail_expect, ex);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!mem_en && fail, "R6 quiet after fail", {mem_en, fail}, 2'b01);
    end
    q.delete();
    flt_en = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!done && !fail && !mem_en && ops_seen == 0, "R1 reset state",
          {done, fail, mem_en}, 0);

    // clean run with a stray start mid-run (R4 R5 R7 R8)
    push_run();
    ops_seen = 0;
    pulse_start();
    repeat (30) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_end();
    check(done && !fail, "R7 clean run done", {done, fail}, 2'b10);
    check(q.size() == 0, "R4 all accesses seen", q.size(), 0);
    check(ops_seen == 10 * N, "R5 access count", ops_seen, 10 * N);
    repeat (5) @(negedge clk);
    check(done && !mem_en, "R7 done held", {done, mem_en}, 2'b10);

    // R6 stuck-at-0 on bit0 of addr 2: seen as variable read in phase 0
    fault_run(4'd2, 8'h01, 8'h00, 8'h55, "R6 var read");
    // R5 stuck-at-1 on bit7 of addr 5: only the inverted phase exposes it
    fault_run(4'd5, 8'h80, 8'h80, 8'h55, "R5 inverted phase");
    // R3 stuck-at-0 on bit1 of addr 15: first read as partner of addr 0
    fault_run(4'd15, 8'h02, 8'h00, 8'hAA, "R3 partner read");

    // R8 restart after a failure clears flags and runs clean
    push_run();
    ops_seen = 0;
    pulse_start();
    @(negedge clk);
    check(!done && !fail, "R8 flags cleared on start", {done, fail}, 0);
    wait_end();
    check(done && !fail && q.size() == 0, "R8 restart completes",
          {done, fail}, 2'b10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule